// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block sits between register renaming and the execution units of an out-of-order core. It keeps renamed instructions in a small issue queue until their source physical registers hold valid results. It then hands them to three execution ports: two arithmetic ports with a latency of one cycle, and one memory port that is pipelined over three stages. A readiness bit per physical register tracks which results exist. Each port picks the oldest instruction of its class whose sources are all ready.

Up to two renamed instructions arrive per cycle. Each one carries an operation class, two optional source tags and an optional destination tag. Every issue port drives the queue index and the tags of the instruction it starts. Destination tags become ready again through internal wakeups. An arithmetic result wakes its consumers so that they run back to back with it. A load wakes its consumers so that they first execute in the cycle after the load leaves memory stage 3. Data values, memory ordering and retirement are handled elsewhere.

Top module: `ooo_issue_sched`

## Requirements
- R1: After reset the queue is empty, no port issues, `in_stall` is low, physical tags 1 to 15 are ready and every other tag is not ready.
- R2: Each cycle up to two instructions are accepted, lane 0 counting as older than lane 1. An accepted instruction that writes a register marks its destination tag not ready, even if that tag was ready before.
- R3: An instruction issues only when each source it uses is ready. A store (class 2'b10) uses source A as its address and source B as its data, has no destination, and waits for both.
- R4: An arithmetic instruction (class 2'b00) that issues in cycle t makes its destination ready for consumers issuing in cycle t+1.
- R5: A load (class 2'b01) that issues in cycle t makes its destination ready for consumers issuing in cycle t+3, and not earlier.
- R6: Each arithmetic port takes the oldest ready arithmetic instruction not taken by a lower-numbered port. Port 0 gets the oldest, port 1 the next, and the two never carry the same entry.
- R7: Loads and stores share the memory port. It takes the oldest ready memory instruction every cycle, so a new memory instruction may start while earlier ones are still in stages 2 and 3.
- R8: An issued entry is free in the next cycle. `in_stall` is high whenever fewer than two entries are free, and instructions offered while it is high are dropped.
- R9: An instruction whose source is woken in the same cycle it is inserted does not lose that wakeup. It can issue in the next cycle.
- R10: An issue port is valid in the cycle its instruction is chosen, and it carries that instruction's queue index and tags. For a store the memory port's source B is the data tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 2 | Lane valid, one bit per insertion lane |
| in_cls | input | 4 | Operation class per lane: 00 arithmetic, 01 load, 10 store |
| in_use_a | input | 2 | Source A is used, per lane |
| in_src_a | input | 2*TAG_W | Source A tag per lane |
| in_use_b | input | 2 | Source B is used, per lane |
| in_src_b | input | 2*TAG_W | Source B tag per lane |
| in_use_dst | input | 2 | Destination written, per lane |
| in_dst | input | 2*TAG_W | Destination tag per lane |
| in_stall | output | 1 | Fewer than two free queue entries; inputs are dropped |
| alu_vld | output | NUM_ALU | Arithmetic port issue valid |
| alu_idx | output | NUM_ALU*IDX_W | Queue index per arithmetic port |
| alu_src_a | output | NUM_ALU*TAG_W | Source A tag per arithmetic port |
| alu_src_b | output | NUM_ALU*TAG_W | Source B tag per arithmetic port |
| alu_dst | output | NUM_ALU*TAG_W | Destination tag per arithmetic port |
| mem_vld | output | 1 | Memory port issue valid |
| mem_store | output | 1 | Memory port carries a store |
| mem_idx | output | IDX_W | Queue index on the memory port |
| mem_src_a | output | TAG_W | Address tag on the memory port |
| mem_src_b | output | TAG_W | Store data tag on the memory port |
| mem_dst | output | TAG_W | Load destination tag on the memory port |

## Verification
An instruction offered in cycle c can first show up on an issue port in cycle c+1. The consumer of an arithmetic result issued in cycle t is due on a port in cycle t+1, and the consumer of a load is due in cycle t+3. Both are also checked to be absent in the cycles before. The stall flag follows the queue occupancy left by the previous edge. The bench drives inputs just after each rising edge and reads the ports at the following falling edge, so each expected value is compared in the exact cycle it is due.

// File: rtl/sched_pkg.sv
// Shared types for the issue scheduler.
// Assumes: class encoding is fixed and decoded by the bench and the top.
package sched_pkg;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STORE = 2'b10
    } op_cls_e;

    localparam int INS_LANES = 2;

endpackage

// File: rtl/sched_scoreboard.sv
// Physical register ready bits.
// Sets come from wakeup broadcasts and clears come from destination allocation.
// A clear wins over a set to the same tag in one cycle.
// Assumes: tags 1..NUM_BOOT_READY hold architectural values at reset.
module sched_scoreboard #(
    parameter int TAG_W          = 6,
    parameter int NUM_PREGS      = 64,
    parameter int NUM_BOOT_READY = 15,
    parameter int NUM_SET        = 3,
    parameter int NUM_CLR        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SET-1:0]         set_vld,
    input  logic [NUM_SET*TAG_W-1:0]   set_tag,
    input  logic [NUM_CLR-1:0]         clr_vld,
    input  logic [NUM_CLR*TAG_W-1:0]   clr_tag,
    output logic [NUM_PREGS-1:0]       rdy
);

    function automatic logic [NUM_PREGS-1:0] boot_mask();
        logic [NUM_PREGS-1:0] m;
        for (int i = 0; i < NUM_PREGS; i++) begin
            m[i] = (i >= 1) && (i <= NUM_BOOT_READY);
        end
        return m;
    endfunction

    localparam logic [NUM_PREGS-1:0] BOOT_MASK = boot_mask();

    logic [NUM_PREGS-1:0] rdy_q;
    logic [NUM_PREGS-1:0] rdy_nxt;

    // Next ready vector: apply broadcasts, then allocation clears.
    always_comb begin
        rdy_nxt = rdy_q;
        for (int s = 0; s < NUM_SET; s++) begin
            if (set_vld[s]) rdy_nxt[set_tag[s*TAG_W +: TAG_W]] = 1'b1;
        end
        for (int c = 0; c < NUM_CLR; c++) begin
            if (clr_vld[c]) rdy_nxt[clr_tag[c*TAG_W +: TAG_W]] = 1'b0;
        end
    end

    // Ready bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= BOOT_MASK;
        else        rdy_q <= rdy_nxt;
    end

    assign rdy = rdy_q;

    // A set that no clear in the same cycle overrides.
    logic [NUM_SET-1:0] set_clean;
    always_comb begin
        for (int s = 0; s < NUM_SET; s++) begin
            set_clean[s] = set_vld[s];
            for (int c = 0; c < NUM_CLR; c++) begin
                if (clr_vld[c] && clr_tag[c*TAG_W +: TAG_W] == set_tag[s*TAG_W +: TAG_W])
                    set_clean[s] = 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NUM_CLR; c++) begin : g_clr_chk
        // R2: an allocated destination reads not ready in the next cycle
        a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vld[c] |=> !rdy_q[$past(clr_tag[c*TAG_W +: TAG_W])]);
    end

    for (genvar s = 0; s < NUM_SET; s++) begin : g_set_chk
        // R4/R5: a broadcast tag reads ready in the next cycle
        a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_clean[s] |=> rdy_q[$past(set_tag[s*TAG_W +: TAG_W])]);
    end

endmodule

// File: rtl/sched_age_matrix.sv
// Relative age of the queue entries.
// Bit j*N+i is set when entry j is older than entry i.
// Assumes: two allocations per cycle at most, lane 0 older than lane 1.
module sched_age_matrix #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       alloc_vld,
    input  logic [2*IDX_W-1:0] alloc_idx,
    output logic [N*N-1:0]   older
);

    logic [N*N-1:0] older_q;
    logic [N*N-1:0] older_nxt;

    // A new entry is younger than every entry; lane 1 is applied after lane 0.
    always_comb begin
        older_nxt = older_q;
        for (int k = 0; k < 2; k++) begin
            if (alloc_vld[k]) begin
                for (int j = 0; j < N; j++) begin
                    older_nxt[j*N + int'(alloc_idx[k*IDX_W +: IDX_W])] = 1'b1;
                end
                for (int j = 0; j < N; j++) begin
                    older_nxt[int'(alloc_idx[k*IDX_W +: IDX_W])*N + j] = 1'b0;
                end
            end
        end
    end

    // Age matrix register.
    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_nxt;
    end

    assign older = older_q;

endmodule

// File: rtl/sched_oldest_pick.sv
// Picks the oldest requesting entry using the age matrix.
// Assumes: the matrix diagonal is zero, so an entry never blocks itself.
module sched_oldest_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N*N-1:0]   older,
    output logic [N-1:0]     gnt,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);

    // An entry wins when no older entry also requests.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                blocked = blocked | (req[j] & older[j*N + i]);
            end
            gnt[i] = req[i] & ~blocked;
        end
    end

    // Encode the winner.
    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) gnt_idx = IDX_W'(i);
        end
        gnt_vld = |gnt;
    end

    // R6: at most one winner per picker
    a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

endmodule

// File: rtl/sched_mem_pipe.sv
// Tracks loads through the memory stages and broadcasts their destination.
// The broadcast leaves during stage 2, so the ready bit shows in stage 3
// and a consumer issued then executes right after stage 3.
module sched_mem_pipe #(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_wb,
    input  logic [TAG_W-1:0] iss_dst,
    output logic             wake_vld,
    output logic [TAG_W-1:0] wake_tag
);

    logic             st1_vld, st2_vld;
    logic [TAG_W-1:0] st1_tag, st2_tag;

    // Advance the load through stages 1 and 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_vld <= 1'b0;
            st2_vld <= 1'b0;
            st1_tag <= '0;
            st2_tag <= '0;
        end else begin
            st1_vld <= iss_wb;
            st1_tag <= iss_dst;
            st2_vld <= st1_vld;
            st2_tag <= st1_tag;
        end
    end

    assign wake_vld = st2_vld;
    assign wake_tag = st2_tag;

    // R5: a load wakeup leaves exactly two cycles after the load issued
    a_r5_wake_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vld |-> $past(iss_wb, 2) && wake_tag == $past(iss_dst, 2));

endmodule

// File: rtl/ooo_issue_sched.sv
// Issue queue with ready-bit wakeup and oldest-first select.
// It feeds NUM_ALU one-cycle arithmetic ports and one memory port
// pipelined over three stages.
// Assumes: renaming never hands out a tag that is still in flight, and
// loads and stores never overlap, so memory operations issue in any order.
module ooo_issue_sched
    import sched_pkg::*;
#(
    parameter int TAG_W          = 6,
    parameter int NUM_PREGS      = 64,
    parameter int NUM_BOOT_READY = 15,
    parameter int IQ_DEPTH       = 8,
    parameter int NUM_ALU        = 2,
    localparam int IDX_W         = (IQ_DEPTH > 1) ? $clog2(IQ_DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 in_vld,
    input  logic [3:0]                 in_cls,
    input  logic [1:0]                 in_use_a,
    input  logic [2*TAG_W-1:0]         in_src_a,
    input  logic [1:0]                 in_use_b,
    input  logic [2*TAG_W-1:0]         in_src_b,
    input  logic [1:0]                 in_use_dst,
    input  logic [2*TAG_W-1:0]         in_dst,
    output logic                       in_stall,
    output logic [NUM_ALU-1:0]         alu_vld,
    output logic [NUM_ALU*IDX_W-1:0]   alu_idx,
    output logic [NUM_ALU*TAG_W-1:0]   alu_src_a,
    output logic [NUM_ALU*TAG_W-1:0]   alu_src_b,
    output logic [NUM_ALU*TAG_W-1:0]   alu_dst,
    output logic                       mem_vld,
    output logic                       mem_store,
    output logic [IDX_W-1:0]           mem_idx,
    output logic [TAG_W-1:0]           mem_src_a,
    output logic [TAG_W-1:0]           mem_src_b,
    output logic [TAG_W-1:0]           mem_dst
);

    localparam int NUM_SET = NUM_ALU + 1;
    localparam int CNT_W   = $clog2(IQ_DEPTH + 1);

    typedef struct packed {
        op_cls_e          cls;
        logic             ua;
        logic [TAG_W-1:0] sa;
        logic             ub;
        logic [TAG_W-1:0] sb;
        logic             ud;
        logic [TAG_W-1:0] d;
    } iq_ent_t;

    iq_ent_t               ent_q [IQ_DEPTH];
    logic [IQ_DEPTH-1:0]   vld_q;
    iq_ent_t               lane  [INS_LANES];
    logic [INS_LANES-1:0]  acc;
    logic [NUM_PREGS-1:0]  sb_rdy;

    // Unpack the two insertion lanes.
    always_comb begin
        for (int k = 0; k < INS_LANES; k++) begin
            lane[k].cls = op_cls_e'(in_cls[2*k +: 2]);
            lane[k].ua  = in_use_a[k];
            lane[k].sa  = in_src_a[k*TAG_W +: TAG_W];
            lane[k].ub  = in_use_b[k];
            lane[k].sb  = in_src_b[k*TAG_W +: TAG_W];
            lane[k].ud  = in_use_dst[k] && (op_cls_e'(in_cls[2*k +: 2]) != CLS_STORE);
            lane[k].d   = in_dst[k*TAG_W +: TAG_W];
        end
    end

    // Find the two lowest free entries and count free space.
    logic [IDX_W-1:0] free0, free1;
    logic             free0_ok, free1_ok;
    logic [CNT_W-1:0] free_cnt;
    always_comb begin
        free0 = '0; free1 = '0;
        free0_ok = 1'b0; free1_ok = 1'b0;
        free_cnt = '0;
        for (int i = 0; i < IQ_DEPTH; i++) begin
            if (!vld_q[i]) begin
                free_cnt = free_cnt + 1'b1;
                if (!free0_ok) begin
                    free0 = IDX_W'(i); free0_ok = 1'b1;
                end else if (!free1_ok) begin
                    free1 = IDX_W'(i); free1_ok = 1'b1;
                end
            end
        end
    end

    assign in_stall = (free_cnt < CNT_W'(2));
    assign acc      = in_vld & {INS_LANES{~in_stall}};

    // Entries that are ready, split by port class.
    logic [IQ_DEPTH-1:0] req_alu, req_mem;
    for (genvar i = 0; i < IQ_DEPTH; i++) begin : g_ready
        logic src_ok;
        assign src_ok     = (!ent_q[i].ua || sb_rdy[ent_q[i].sa]) &&
                            (!ent_q[i].ub || sb_rdy[ent_q[i].sb]);
        assign req_alu[i] = vld_q[i] && src_ok && (ent_q[i].cls == CLS_ALU);
        assign req_mem[i] = vld_q[i] && src_ok &&
                            (ent_q[i].cls == CLS_LOAD || ent_q[i].cls == CLS_STORE);
    end

    // Age matrix for oldest-first select.
    logic [IQ_DEPTH*IQ_DEPTH-1:0] older;
    sched_age_matrix #(.N(IQ_DEPTH), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vld (acc),
        .alloc_idx ({free1, free0}),
        .older     (older)
    );

    // Arithmetic pickers chained so each port skips the entries taken above it.
    logic [IQ_DEPTH-1:0] alu_req [NUM_ALU];
    logic [IQ_DEPTH-1:0] alu_gnt [NUM_ALU];
    logic [IDX_W-1:0]    alu_sel [NUM_ALU];
    logic [IQ_DEPTH-1:0] alu_taken;
    for (genvar p = 0; p < NUM_ALU; p++) begin : g_alu
        if (p == 0) begin : g_first
            assign alu_req[p] = req_alu;
        end else begin : g_next
            assign alu_req[p] = alu_req[p-1] & ~alu_gnt[p-1];
        end
        sched_oldest_pick #(.N(IQ_DEPTH), .IDX_W(IDX_W)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (alu_req[p]),
            .older   (older),
            .gnt     (alu_gnt[p]),
            .gnt_vld (alu_vld[p]),
            .gnt_idx (alu_sel[p])
        );
        assign alu_idx[p*IDX_W +: IDX_W]   = alu_sel[p];
        assign alu_src_a[p*TAG_W +: TAG_W] = ent_q[alu_sel[p]].sa;
        assign alu_src_b[p*TAG_W +: TAG_W] = ent_q[alu_sel[p]].sb;
        assign alu_dst[p*TAG_W +: TAG_W]   = ent_q[alu_sel[p]].d;
    end

    // Union of the arithmetic grants.
    always_comb begin
        alu_taken = '0;
        for (int p = 0; p < NUM_ALU; p++) alu_taken = alu_taken | alu_gnt[p];
    end

    // Memory picker: loads and stores share one port.
    logic [IQ_DEPTH-1:0] mem_gnt;
    sched_oldest_pick #(.N(IQ_DEPTH), .IDX_W(IDX_W)) u_pick_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_mem),
        .older   (older),
        .gnt     (mem_gnt),
        .gnt_vld (mem_vld),
        .gnt_idx (mem_idx)
    );
    assign mem_store = (ent_q[mem_idx].cls == CLS_STORE);
    assign mem_src_a = ent_q[mem_idx].sa;
    assign mem_src_b = ent_q[mem_idx].sb;
    assign mem_dst   = ent_q[mem_idx].d;

    // Load wakeup delay line.
    logic             ld_wake;
    logic [TAG_W-1:0] ld_wake_tag;
    sched_mem_pipe #(.TAG_W(TAG_W)) u_mem_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_wb   (mem_vld && ent_q[mem_idx].cls == CLS_LOAD && ent_q[mem_idx].ud),
        .iss_dst  (ent_q[mem_idx].d),
        .wake_vld (ld_wake),
        .wake_tag (ld_wake_tag)
    );

    // Broadcast sources: arithmetic issue (same cycle) and delayed loads.
    logic [NUM_SET-1:0]       set_vld;
    logic [NUM_SET*TAG_W-1:0] set_tag;
    always_comb begin
        for (int p = 0; p < NUM_ALU; p++) begin
            set_vld[p]                = alu_vld[p] && ent_q[alu_sel[p]].ud;
            set_tag[p*TAG_W +: TAG_W] = ent_q[alu_sel[p]].d;
        end
        set_vld[NUM_ALU]                = ld_wake;
        set_tag[NUM_ALU*TAG_W +: TAG_W] = ld_wake_tag;
    end

    // Allocation clears for accepted destinations.
    logic [INS_LANES-1:0]       clr_vld;
    logic [INS_LANES*TAG_W-1:0] clr_tag;
    always_comb begin
        for (int k = 0; k < INS_LANES; k++) begin
            clr_vld[k]                = acc[k] && lane[k].ud;
            clr_tag[k*TAG_W +: TAG_W] = lane[k].d;
        end
    end

    sched_scoreboard #(
        .TAG_W          (TAG_W),
        .NUM_PREGS      (NUM_PREGS),
        .NUM_BOOT_READY (NUM_BOOT_READY),
        .NUM_SET        (NUM_SET),
        .NUM_CLR        (INS_LANES)
    ) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (set_vld),
        .set_tag (set_tag),
        .clr_vld (clr_vld),
        .clr_tag (clr_tag),
        .rdy     (sb_rdy)
    );

    // Entry occupancy: free issued entries, fill accepted lanes.
    logic [IQ_DEPTH-1:0] issued;
    logic [IQ_DEPTH-1:0] alloc_mask;
    always_comb begin
        issued     = alu_taken | mem_gnt;
        alloc_mask = '0;
        if (acc[0]) alloc_mask[free0] = 1'b1;
        if (acc[1]) alloc_mask[free1] = 1'b1;
    end

    // Valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= (vld_q & ~issued) | alloc_mask;
    end

    // Entry payload; only meaningful while the valid bit is set.
    always_ff @(posedge clk) begin
        if (acc[0]) ent_q[free0] <= lane[0];
        if (acc[1]) ent_q[free1] <= lane[1];
    end

    // R10: every grant points at a live entry
    a_r10_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((alu_taken | mem_gnt) & ~vld_q) == '0);

    // R6: the two arithmetic ports never carry the same entry
    a_r6_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_taken & mem_gnt) == '0 && $countones(alu_taken) == $countones(alu_vld));

    // R8: no entry is added while stalled
    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |=> $countones(vld_q) <= $past($countones(vld_q)));

endmodule

// File: tb/sim_ooo_issue_sched.sv
module sim_ooo_issue_sched;

    localparam int TW = 6;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]      in_vld, in_use_a, in_use_b, in_use_dst;
    logic [3:0]      in_cls;
    logic [2*TW-1:0] in_src_a, in_src_b, in_dst;
    logic            in_stall;
    logic [1:0]      alu_vld;
    logic [2*IW-1:0] alu_idx;
    logic [2*TW-1:0] alu_src_a, alu_src_b, alu_dst;
    logic            mem_vld, mem_store;
    logic [IW-1:0]   mem_idx;
    logic [TW-1:0]   mem_src_a, mem_src_b, mem_dst;

    ooo_issue_sched u0 (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_cls(in_cls),
        .in_use_a(in_use_a), .in_src_a(in_src_a),
        .in_use_b(in_use_b), .in_src_b(in_src_b),
        .in_use_dst(in_use_dst), .in_dst(in_dst),
        .in_stall(in_stall),
        .alu_vld(alu_vld), .alu_idx(alu_idx),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_dst(alu_dst),
        .mem_vld(mem_vld), .mem_store(mem_store), .mem_idx(mem_idx),
        .mem_src_a(mem_src_a), .mem_src_b(mem_src_b), .mem_dst(mem_dst)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Lane word: {vld, cls[2], ua, sa[6], ub, sb[6], ud, d[6]}
    function automatic logic [23:0] ins(logic [1:0] c, logic ua, logic [5:0] a,
                                        logic ub, logic [5:0] b, logic ud, logic [5:0] d);
        return {1'b1, c, ua, a, ub, b, ud, d};
    endfunction
    function automatic logic [23:0] alu2(logic [5:0] a, logic [5:0] b, logic [5:0] d);
        return ins(2'b00, 1'b1, a, 1'b1, b, 1'b1, d);
    endfunction
    function automatic logic [23:0] alu1(logic [5:0] a, logic [5:0] d);
        return ins(2'b00, 1'b1, a, 1'b0, 6'd0, 1'b1, d);
    endfunction
    function automatic logic [23:0] ld(logic [5:0] a, logic [5:0] d);
        return ins(2'b01, 1'b1, a, 1'b0, 6'd0, 1'b1, d);
    endfunction
    function automatic logic [23:0] st(logic [5:0] a, logic [5:0] b);
        return ins(2'b10, 1'b1, a, 1'b1, b, 1'b0, 6'd0);
    endfunction
    localparam logic [23:0] NO = 24'd0;

    // Row: {lane0, lane1, exp alu_vld[2], alu0 dst, alu1 dst, exp mem_vld, mem tag}
    localparam int NV = 9;
    localparam logic [68:0] VEC [NV] = '{
        {ld(5,16),      alu2(5,8,18),  2'b00, 6'd0,  6'd0, 1'b0, 6'd0},
        {alu2(15,2,19), alu2(16,2,20), 2'b01, 6'd18, 6'd0, 1'b1, 6'd16},
        {ld(6,21),      alu2(19,8,22), 2'b01, 6'd19, 6'd0, 1'b0, 6'd0},
        {alu2(21,18,23),ld(22,24),     2'b01, 6'd22, 6'd0, 1'b1, 6'd21},
        {alu2(22,20,25),st(23,25),     2'b01, 6'd20, 6'd0, 1'b1, 6'd24},
        {NO,            NO,            2'b01, 6'd25, 6'd0, 1'b0, 6'd0},
        {NO,            NO,            2'b01, 6'd23, 6'd0, 1'b0, 6'd0},
        {NO,            NO,            2'b00, 6'd0,  6'd0, 1'b1, 6'd25},
        {NO,            NO,            2'b00, 6'd0,  6'd0, 1'b0, 6'd0}
    };

    task automatic put(int k, logic [23:0] l);
        in_vld[k]            = l[23];
        in_cls[2*k +: 2]     = l[22:21];
        in_use_a[k]          = l[20];
        in_src_a[k*TW +: TW] = l[19:14];
        in_use_b[k]          = l[13];
        in_src_b[k*TW +: TW] = l[12:7];
        in_use_dst[k]        = l[6];
        in_dst[k*TW +: TW]   = l[5:0];
    endtask

    // One cycle: drive just after the rising edge, return at the falling edge.
    task automatic cyc(logic [23:0] l0, logic [23:0] l1);
        @(posedge clk);
        #1;
        put(0, l0);
        put(1, l1);
        @(negedge clk);
    endtask

    task automatic chk_alu(string req, logic [1:0] av, logic [5:0] a0, logic [5:0] a1);
        n_run++;
        if (alu_vld !== av || (av[0] && alu_dst[5:0] !== a0) || (av[1] && alu_dst[11:6] !== a1)) begin
            n_fail++;
            $display("FAIL %s alu: vld=%b dst0=%0d dst1=%0d expected vld=%b dst0=%0d dst1=%0d",
                     req, alu_vld, alu_dst[5:0], alu_dst[11:6], av, a0, a1);
        end
    endtask

    task automatic chk_mem(string req, logic mv, logic [5:0] mt);
        logic [5:0] got;
        got = mem_store ? mem_src_b : mem_dst;
        n_run++;
        if (mem_vld !== mv || (mv && got !== mt)) begin
            n_fail++;
            $display("FAIL %s mem: vld=%b tag=%0d expected vld=%b tag=%0d",
                     req, mem_vld, got, mv, mt);
        end
    endtask

    task automatic chk_stall(string req, logic e);
        n_run++;
        if (in_stall !== e) begin
            n_fail++;
            $display("FAIL %s stall: got %b expected %b", req, in_stall, e);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        put(0, NO);
        put(1, NO);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset outputs
        chk_alu("R1", 2'b00, 6'd0, 6'd0);
        chk_mem("R1", 1'b0, 6'd0);
        chk_stall("R1", 1'b0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // Dependency chain; covers R3 (store waits for data), R4, R5, R7, R10
        for (int r = 0; r < NV; r++) begin
            cyc(VEC[r][68:45], VEC[r][44:21]);
            chk_alu("R3/R4/R5 table", VEC[r][20:19], VEC[r][18:13], VEC[r][12:7]);
            chk_mem("R7/R10 table", VEC[r][6], VEC[r][5:0]);
        end

        // R6: three consumers of one load wake together; oldest two first
        cyc(ld(7,40), alu2(40,1,41));
        cyc(alu1(40,42), alu1(40,43));
        chk_mem("R7", 1'b1, 6'd40);
        chk_alu("R5 not early", 2'b00, 6'd0, 6'd0);
        cyc(NO, NO);
        chk_alu("R5 not early", 2'b00, 6'd0, 6'd0);
        cyc(NO, NO);
        chk_alu("R5 not early", 2'b00, 6'd0, 6'd0);
        cyc(NO, NO);
        chk_alu("R6 two oldest", 2'b11, 6'd41, 6'd42);
        cyc(NO, NO);
        chk_alu("R6 youngest next", 2'b01, 6'd43, 6'd0);

        // R9: insertion in the same cycle as the wakeup
        cyc(alu2(1,2,33), ld(3,35));
        cyc(alu2(33,1,34), NO);
        chk_alu("R4", 2'b01, 6'd33, 6'd0);
        chk_mem("R7", 1'b1, 6'd35);
        cyc(NO, NO);
        chk_alu("R9 alu wake", 2'b01, 6'd34, 6'd0);
        cyc(alu1(35,36), NO);
        chk_alu("R9 idle", 2'b00, 6'd0, 6'd0);
        cyc(NO, NO);
        chk_alu("R9 load wake", 2'b01, 6'd36, 6'd0);

        // R2: reallocating a ready tag makes its consumer wait
        cyc(alu2(1,2,33), alu2(33,1,39));
        cyc(NO, NO);
        chk_alu("R2 clear", 2'b01, 6'd33, 6'd0);
        cyc(NO, NO);
        chk_alu("R2 after wake", 2'b01, 6'd39, 6'd0);

        // R8: fill the queue, offer while stalled, drain
        cyc(ld(7,50), alu1(50,51));
        cyc(alu1(50,52), alu1(50,53));
        chk_stall("R8", 1'b0);
        cyc(alu1(50,54), alu1(50,55));
        chk_stall("R8", 1'b0);
        cyc(alu1(50,56), alu1(50,57));
        chk_stall("R8", 1'b0);
        cyc(alu2(1,2,58), NO);
        chk_stall("R8 full", 1'b1);
        chk_alu("R8", 2'b11, 6'd51, 6'd52);
        cyc(NO, NO);
        chk_stall("R8 freed", 1'b0);
        chk_alu("R8", 2'b11, 6'd53, 6'd54);
        cyc(NO, NO);
        chk_alu("R8", 2'b11, 6'd55, 6'd56);
        cyc(NO, NO);
        chk_alu("R8", 2'b01, 6'd57, 6'd0);
        cyc(NO, NO);
        chk_alu("R8 dropped", 2'b00, 6'd0, 6'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule